// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Its logic runs on the test clock. It is steered by the mode-select line through the sixteen-state controller defined by IEEE 1149.1. The port holds a 4-bit instruction register with no parity bit, a single-bit bypass stage and a boundary chain whose length is a parameter. The boundary chain captures the chip's pin values in parallel and presents the shifted-in values as update outputs, which the pad ring can drive onto the pins.

Five opcodes are decoded. Two of them place the boundary chain between the serial input and the serial output: the external-test opcode and the sample/preload opcode. The external-test opcode also makes the pads drive the update values and holds the core in soft reset while it is the current instruction. The sample/preload opcode leaves the pins in normal operation. The high-impedance opcode floats every pin. The clamp opcode drives the update values onto the pins while the bypass stage is selected. Every other code selects bypass. The port returns to the reset state when the asynchronous active-low reset is asserted, or after five test clocks with the mode-select line held high. In the reset state the chip behaves normally.

Top module: `scan_port`

## Requirements
- R1: While `trst_n` is low, and without waiting for a clock edge, the controller is in Test-Logic-Reset. The instruction reverts to a bypass code, `tdo_oe` is 0, `pins_from_cells`, `pins_hiz` and `core_soft_rst` are 0, and `cell_q` is all zeros.
- R2: Five consecutive rising `tck` edges with `tms`=1 bring the controller to Test-Logic-Reset from any state. This clears the current instruction to bypass, which drops `core_soft_rst`.
- R3: Capture-IR loads the binary pattern 0001 into the instruction shift stage. Shift-IR then presents it on `tdo` least significant bit first, so the first four bits out are 1, 0, 0, 0.
- R4: The opcode is decoded from bit 3 down to bit 0 as follows. 0000 selects external test and 0001 selects sample/preload. 0100 selects high-impedance and 0101 selects clamp. Codes of the form 0?1? select bypass, and so does every code with bit 3 set.
- R5: Under every opcode other than 0000 and 0001, the data path is the bypass stage. Capture-DR clears it to 0. A bit shifted in on `tdi` appears on `tdo` one shift cycle later.
- R6: Under 0000 and 0001, Capture-DR loads `pin_in` into the chain. Shift-DR moves the chain towards `tdo` with `pin_in[0]` first, and `tdi` enters at the top, so a bit comes out `CHAIN_LEN` shift cycles after it is shifted in.
- R7: Update-DR under 0000 or 0001 copies the chain into `cell_q`. After shifting `CHAIN_LEN`+1 bits d0..dN, `cell_q[k]` = d(k+1). Under any other opcode, `cell_q` keeps its value through a full data scan.
- R8: `pins_from_cells` is 1 under 0000 and 0101. `pins_hiz` is 1 under 0100 only. Under 0001, both are 0.
- R9: `core_soft_rst` is 1 exactly while 0000 is the current instruction.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: A new opcode takes effect only after Update-IR. While it is being shifted in, the decoded outputs still follow the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| pin_in | input | CHAIN_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable of `tdo`, high while shifting |
| cell_q | output | CHAIN_LEN | Boundary update values |
| pins_from_cells | output | 1 | Pads drive `cell_q` instead of core values |
| pins_hiz | output | 1 | Force all pad output enables off |
| core_soft_rst | output | 1 | Soft-reset request to the core logic |

## Verification
The bench reads `tdo` just after each falling edge. That value is the bit for the current shift cycle, loaded from the state and chain contents left by the previous rising edge. The bench then reads `tdo` again just after the next rising edge to confirm the value has not moved. Decoded outputs are checked three time units after the rising edge that leaves Update-IR, because the instruction loads on that edge. Their pre-update values are checked one edge earlier. `cell_q` is checked after the edge that leaves Update-DR. The asynchronous reset is checked one time unit after `trst_n` falls, between clock edges. All sixteen opcodes are swept, each with its own pin and data pattern, and every expected bit stream is computed from the path length.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int unsigned OP_W = 4;

    localparam logic [OP_W-1:0] OP_EXT_TEST  = 4'b0000;
    localparam logic [OP_W-1:0] OP_SAMPLE    = 4'b0001;
    localparam logic [OP_W-1:0] OP_FLOAT     = 4'b0100;
    localparam logic [OP_W-1:0] OP_CLAMP     = 4'b0101;
    localparam logic [OP_W-1:0] OP_IDLE_BYP  = 4'b0011;
    localparam logic [OP_W-1:0] IR_CAP_PAT   = 4'b0001;

    typedef struct packed {
        logic chain_sel;
        logic cells_drive;
        logic pins_float;
        logic core_rst;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [OP_W-1:0] op);
        op_ctl_t c;
        c = '0;
        case (op)
            OP_EXT_TEST: begin
                c.chain_sel   = 1'b1;
                c.cells_drive = 1'b1;
                c.core_rst    = 1'b1;
            end
            OP_SAMPLE: c.chain_sel   = 1'b1;
            OP_FLOAT:  c.pins_float  = 1'b1;
            OP_CLAMP:  c.cells_drive = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // R2: five high mode-select samples always end in Test-Logic-Reset
    a_r2_tms_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == ST_RESET));

endmodule

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [OP_W-1:0] op_q,
    output logic            sh_out
);

    typedef struct packed {
        logic [OP_W-1:0] sh;
        logic [OP_W-1:0] cur;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_CAP_IR: r_d.sh  = IR_CAP_PAT;
            ST_SH_IR:  r_d.sh  = {tdi, r_q.sh[OP_W-1:1]};
            ST_UPD_IR: r_d.cur = r_q.sh;
            ST_RESET:  r_d.cur = OP_IDLE_BYP;
            default:   r_d = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: IR_CAP_PAT, cur: OP_IDLE_BYP};
        else         r_q <= r_d;
    end

    assign op_q   = r_q.cur;
    assign sh_out = r_q.sh[0];

    // R3: capture always loads the fixed pattern
    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (r_q.sh == IR_CAP_PAT));

    // R11: the active opcode moves only out of Update-IR or Test-Logic-Reset
    a_r11_opcode_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(r_q.cur));

endmodule

// File: rtl/scan_bsr.sv
`timescale 1ns/1ps
module scan_bsr
    import scan_pkg::*;
#(
    parameter int unsigned LEN = 8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  tap_state_e     state,
    input  logic           sel,
    input  logic           tdi,
    input  logic [LEN-1:0] pin_in,
    output logic [LEN-1:0] upd_q,
    output logic           sh_out
);

    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [LEN-1:0] upd;
    } bsr_regs_t;

    bsr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel) begin
            case (state)
                ST_CAP_DR: r_d.sh  = pin_in;
                ST_SH_DR:  r_d.sh  = {tdi, r_q.sh[LEN-1:1]};
                ST_UPD_DR: r_d.upd = r_q.sh;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign upd_q  = r_q.upd;
    assign sh_out = r_q.sh[0];

    // R6: capture takes the pin values present at the edge
    a_r6_capture_pins: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && sel) |=> (r_q.sh == $past(pin_in)));

    // R7: update cells move only in Update-DR with the chain selected
    a_r7_cells_hold: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_DR && sel) |=> $stable(r_q.upd));

endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
    import scan_pkg::*;
#(
    parameter int unsigned CHAIN_LEN = 8
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic                 tdo,
    output logic                 tdo_oe,
    output logic [CHAIN_LEN-1:0] cell_q,
    output logic                 pins_from_cells,
    output logic                 pins_hiz,
    output logic                 core_soft_rst
);

    typedef struct packed {
        logic data;
        logic oe;
    } out_regs_t;

    tap_state_e      state;
    logic [OP_W-1:0] op;
    logic            ir_bit;
    logic            chain_bit;
    op_ctl_t         ctl;
    logic            byp_d, byp_q;
    out_regs_t       out_d, out_q;

    scan_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state)
    );

    scan_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .op_q   (op),
        .sh_out (ir_bit)
    );

    assign ctl = decode_op(op);

    scan_bsr #(.LEN(CHAIN_LEN)) u_bsr (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .sel    (ctl.chain_sel),
        .tdi    (tdi),
        .pin_in (pin_in),
        .upd_q  (cell_q),
        .sh_out (chain_bit)
    );

    always_comb begin
        byp_d = byp_q;
        if (state == ST_CAP_DR)     byp_d = 1'b0;
        else if (state == ST_SH_DR) byp_d = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) byp_q <= 1'b0;
        else         byp_q <= byp_d;
    end

    always_comb begin
        out_d = '0;
        if (state == ST_SH_IR) begin
            out_d.data = ir_bit;
            out_d.oe   = 1'b1;
        end else if (state == ST_SH_DR) begin
            out_d.data = ctl.chain_sel ? chain_bit : byp_q;
            out_d.oe   = 1'b1;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo             = out_q.data;
    assign tdo_oe          = out_q.oe;
    assign pins_from_cells = ctl.cells_drive;
    assign pins_hiz        = ctl.pins_float;
    assign core_soft_rst   = ctl.core_rst;

    // R10: output enable only while a shift state is current
    a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R9: soft reset can only start after an instruction update
    a_r9_soft_rst_start: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(core_soft_rst) |-> ($past(state) == ST_UPD_IR));

    // R8: pads never floated and driven from cells at once
    a_r8_pad_modes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        !(pins_hiz && pins_from_cells));

    // R5: capture clears the bypass stage
    a_r5_bypass_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: tb/scan_port_tb_top.sv
`timescale 1ns/1ps
module scan_port_tb_top;

    localparam int N = 8;
    localparam int SL = N + 1;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_in = '0;
    wire          tdo, tdo_oe, pins_from_cells, pins_hiz, core_soft_rst;
    wire  [N-1:0] cell_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic oe_seen;

    always #10 tck = ~tck;

    scan_port #(.CHAIN_LEN(N)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .cell_q(cell_q),
        .pins_from_cells(pins_from_cells), .pins_hiz(pins_hiz),
        .core_soft_rst(core_soft_rst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #2;
        o = tdo;
        oe_seen = tdo_oe;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap, output logic mid_rst);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) tick(i == 3, op[i], cap[i]);
        tick(1, 0, o);
        #1;
        mid_rst = core_soft_rst;
        tick(0, 0, o);
        #3;
    endtask

    task automatic scan_dr(input logic [SL-1:0] din, output logic [SL-1:0] dout,
                           output logic oe_all, output logic held);
        logic o;
        oe_all = 1'b1;
        held = 1'b1;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < SL; i++) begin
            tick(i == SL - 1, din[i], dout[i]);
            oe_all &= oe_seen;
            #2;
            if (tdo !== dout[i]) held = 1'b0;
        end
        tick(1, 0, o); tick(0, 0, o);
        #3;
    endtask

    function automatic logic [SL-1:0] bypass_exp(input logic [SL-1:0] din);
        return {din[SL-2:0], 1'b0};
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]   cap;
        logic         mid, oe_all, held, o;
        logic [SL-1:0] din, dout;
        logic [3:0]   prev_op;
        logic [N-1:0] prev_cells;

        #25;
        // R1 reset state while trst_n is low
        chk("R1", "tdo_oe in reset", tdo_oe, 0);
        chk("R1", "pad/core controls in reset",
            {pins_from_cells, pins_hiz, core_soft_rst}, 0);
        chk("R1", "cells in reset", cell_q, 0);
        #20 trst_n = 1'b1;

        tick(0, 0, o);  // to Run-Test/Idle
        // R5 default instruction after reset is bypass
        din = 9'h1B5;
        scan_dr(din, dout, oe_all, held);
        chk("R5", "default bypass stream", dout, bypass_exp(din));
        chk("R10", "oe during shift", oe_all, 1);
        chk("R10", "tdo held across rising edge", held, 1);
        chk("R10", "oe after shift", tdo_oe, 0);

        prev_op = 4'b0011;
        prev_cells = '0;
        for (int op = 0; op < 16; op++) begin
            logic bsr, drv, flt, rst;
            logic [SL-1:0] exp;
            bsr = (op == 0) || (op == 1);
            drv = (op == 0) || (op == 5);
            flt = (op == 4);
            rst = (op == 0);
            pin_in = N'(8'h5A ^ (op * 29));
            din = SL'(op * 16'h1357 + 16'h00A9);
            load_ir(4'(op), cap, mid);
            chk("R3", $sformatf("ir capture op=%0d", op), cap, 4'b0001);
            chk("R11", $sformatf("soft reset before update op=%0d", op), mid, prev_op == 4'b0000);
            chk("R4", $sformatf("decode op=%0d", op),
                {pins_from_cells, pins_hiz, core_soft_rst}, {drv, flt, rst});
            chk("R8", $sformatf("pad controls op=%0d", op), {pins_from_cells, pins_hiz}, {drv, flt});
            chk("R9", $sformatf("soft reset op=%0d", op), core_soft_rst, rst);
            scan_dr(din, dout, oe_all, held);
            if (bsr) begin
                exp = {din[0], pin_in};
                chk("R6", $sformatf("chain stream op=%0d", op), dout, exp);
                chk("R7", $sformatf("cells updated op=%0d", op), cell_q, din[SL-1:1]);
                prev_cells = din[SL-1:1];
            end else begin
                chk("R5", $sformatf("bypass stream op=%0d", op), dout, bypass_exp(din));
                chk("R7", $sformatf("cells unchanged op=%0d", op), cell_q, prev_cells);
            end
            chk("R10", $sformatf("oe/hold op=%0d", op), {oe_all, held}, 2'b11);
            prev_op = 4'(op);
        end

        // R2 five high mode-select clocks return to reset
        load_ir(4'b0000, cap, mid);
        chk("R9", "external test reloaded", core_soft_rst, 1);
        for (int i = 0; i < 5; i++) tick(1, 0, o);
        #3;
        chk("R2", "controls after tms reset",
            {pins_from_cells, pins_hiz, core_soft_rst}, 0);
        tick(0, 0, o);
        din = 9'h0D3;
        scan_dr(din, dout, oe_all, held);
        chk("R2", "bypass after tms reset", dout, bypass_exp(din));

        // R1 asynchronous reset between edges
        load_ir(4'b0000, cap, mid);
        @(posedge tck);
        #5 trst_n = 1'b0;
        #1;
        chk("R1", "async controls", {pins_from_cells, pins_hiz, core_soft_rst}, 0);
        chk("R1", "async cells", cell_q, 0);
        #30 trst_n = 1'b1;
        tick(0, 0, o);
        din = 9'h156;
        scan_dr(din, dout, oe_all, held);
        chk("R1", "bypass after async reset", dout, bypass_exp(din));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule